// File: doc/BRIEF.md
# Comparator Output Conditioner with Edge Flags

This block is the digital back end behind an analog comparator. Each clock it synchronises the comparator's raw decision and turns it into a conditioned result. That result appears on a readable status bit, and also on an output pin in either true or inverted polarity. A one-byte control register selects enable, timing mode, a sample-hold request, output polarity, the deglitch filter and two interrupt enables. A second write port clears the edge flags by writing a 1.

There are two timing modes. In clocked auto-zero mode the block alternates between an offset-cancel cycle (S_AZ), which takes no sample, and an evaluation cycle (S_EVAL). Valid samples pass through the selected filter, and a change in the filtered value sets a sticky rising or falling flag. The flag chosen depends on the pin polarity. In continuous mode (S_CONT) the synchronised input is copied to the result every clock and no flags are raised. When the block is disabled it rests in S_OFF.

The FSM has these transitions. S_OFF goes to S_AZ or S_CONT when enabled. S_AZ goes to S_EVAL, and S_EVAL goes back to S_AZ. Any state goes to the entry state of its target class (S_OFF, S_AZ or S_CONT) on a restart. A restart happens when the written control bits 5..0 differ from the stored ones, or when the selected mode class changes. A restart empties the filter history.

Top module: `cmp_conditioner`

## Requirements
- R1: After reset all outputs are 0 and the control register is 0. Writing only bit 0 (enable) therefore selects clocked auto-zero mode, because bit 1 = 0 means clocked.
- R2: In clocked mode the evaluation and auto-zero cycles alternate. A raw input that toggles every clock is therefore always sampled in the same phase, and the result stays constant.
- R3: The block runs in clocked mode when control bit 1 is 0, or when control bit 2 (sample-hold request) is 1, or while input `sar_busy` is 1.
- R4: In continuous mode (bit 1 = 1, bit 2 = 0, `sar_busy` = 0), `cmp_status` equals `cmp_raw` two clocks later, including single-cycle pulses, and no edge flag is set.
- R5: Control bits 5..4 select the filter, which sees only valid samples. 00 = none. 01 = the last 2 samples must be equal. 10 = the last 3 samples must be equal. If the required samples are not equal, the result holds.
- R6: Filter code 11 sets the result to 1 when at least 3 of the last 5 valid samples are 1. Two samples of 1 are not enough.
- R7: `cmp_pin` = `cmp_status` XOR control bit 3 while enabled. A rising flag means the pin went 0 to 1, and a falling flag means the pin went 1 to 0.
- R8: Each flag stays set until a write with `clr_we` = 1 and a 1 in its bit of `clr_wdata` (bit 0 = rising, bit 1 = falling).
- R9: When an edge and a clear of the same flag fall in one cycle, the flag ends up set.
- R10: After a restart, the first full filter window sets a baseline result without raising a flag, even if that result differs from the old one.
- R11: `irq` = (rising flag AND control bit 6) OR (falling flag AND control bit 7). Writing bits 7..6 does not cause a restart.
- R12: While disabled (bit 0 = 0), `cmp_pin` and `cmp_status` are 0 and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Comparator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw | input | 1 | Raw comparator decision |
| sar_busy | input | 1 | Forces clocked mode while a successive-approximation conversion runs |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control value: [0] enable, [1] continuous, [2] sample-hold request, [3] invert, [5:4] filter, [6] rise irq enable, [7] fall irq enable |
| clr_we | input | 1 | Flag clear strobe |
| clr_wdata | input | 2 | Write-1-to-clear: [0] rising, [1] falling |
| cmp_pin | output | 1 | Conditioned result in the selected polarity |
| cmp_status | output | 1 | Conditioned result in true polarity |
| rise_flag | output | 1 | Sticky rising-edge flag |
| fall_flag | output | 1 | Sticky falling-edge flag |
| irq | output | 1 | Interrupt request |

## Verification
A filtered edge and a software clear of the same flag can land on the same clock. To provoke this, the bench holds the clear strobe high on every cycle while the input changes, so the clear is certain to coincide with the evaluation cycle that detects the edge. The outcome is judged by counting how many sampled cycles show the flag high. A set-priority design shows exactly one such cycle, while a clear-priority design shows none.

// File: rtl/cmpc_pkg.sv
package cmpc_pkg;

    typedef enum logic [1:0] {
        S_OFF  = 2'd0,
        S_AZ   = 2'd1,
        S_EVAL = 2'd2,
        S_CONT = 2'd3
    } cmpc_state_e;

    typedef enum logic [1:0] {
        C_OFF  = 2'd0,
        C_CLK  = 2'd1,
        C_CONT = 2'd2
    } cmpc_cls_e;

    typedef enum logic [1:0] {
        FILT_NONE  = 2'b00,
        FILT_TWO   = 2'b01,
        FILT_THREE = 2'b10,
        FILT_MAJ   = 2'b11
    } cmpc_filt_e;

    typedef struct packed {
        logic       fall_ie;
        logic       rise_ie;
        cmpc_filt_e filt;
        logic       invert;
        logic       hold_req;
        logic       cont_mode;
        logic       enable;
    } cmpc_cfg_t;

    localparam int CFG_W     = $bits(cmpc_cfg_t);
    localparam int RESTART_W = 6;

endpackage

// File: rtl/cmpc_window.sv
module cmpc_window
    import cmpc_pkg::*;
#(
    parameter int MAJ_LEN = 5,
    parameter int MAJ_THR = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       shift,
    input  logic       sample,
    input  cmpc_filt_e filt,
    output logic       dec_ok,
    output logic       dec_val
);

    localparam int CNT_W = $clog2(MAJ_LEN + 1);

    logic [MAJ_LEN-1:0] hist_q;
    logic [MAJ_LEN-1:0] win;
    logic [CNT_W-1:0]   fill_q;
    logic [CNT_W-1:0]   fill_nx;
    logic [CNT_W-1:0]   ones;

    assign win     = {hist_q[MAJ_LEN-2:0], sample};
    assign fill_nx = (fill_q == CNT_W'(MAJ_LEN)) ? fill_q : fill_q + 1'b1;

    always_comb begin
        ones = '0;
        for (int i = 0; i < MAJ_LEN; i++) begin
            ones = ones + CNT_W'(win[i]);
        end
    end

    always_comb begin
        dec_ok  = 1'b0;
        dec_val = win[0];
        unique case (filt)
            FILT_NONE:  dec_ok = 1'b1;
            FILT_TWO:   dec_ok = (fill_nx >= CNT_W'(2)) && (win[1] == win[0]);
            FILT_THREE: dec_ok = (fill_nx >= CNT_W'(3)) && (win[2] == win[1]) && (win[1] == win[0]);
            FILT_MAJ: begin
                dec_ok  = (fill_nx == CNT_W'(MAJ_LEN));
                dec_val = (ones >= CNT_W'(MAJ_THR));
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
            fill_q <= '0;
        end else if (flush) begin
            hist_q <= '0;
            fill_q <= '0;
        end else if (shift) begin
            hist_q <= win;
            fill_q <= fill_nx;
        end
    end

    // R2: no sample enters the history outside an evaluation cycle
    assert_hist_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !shift) |=> $stable(hist_q));

    // R10: a restart empties the window
    assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fill_q == '0));

endmodule

// File: rtl/cmpc_flags.sv
module cmpc_flags #(
    parameter int N_FLAGS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_FLAGS-1:0] set_i,
    input  logic [N_FLAGS-1:0] clr_i,
    output logic [N_FLAGS-1:0] flag_o
);

    logic [N_FLAGS-1:0] flag_q;

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[g] <= 1'b0;
            end else if (set_i[g]) begin
                flag_q[g] <= 1'b1;
            end else if (clr_i[g]) begin
                flag_q[g] <= 1'b0;
            end
        end

        // R9: a set in the same cycle as a clear leaves the flag high
        assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> flag_q[g]);

        // R8: without a clear the flag is sticky
        assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[g] && !clr_i[g]) |=> flag_q[g]);
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/cmp_conditioner.sv
module cmp_conditioner
    import cmpc_pkg::*;
#(
    parameter int SYNC_STAGES = 1,
    parameter int MAJ_LEN     = 5,
    parameter int MAJ_THR     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_raw,
    input  logic             sar_busy,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             clr_we,
    input  logic [1:0]       clr_wdata,
    output logic             cmp_pin,
    output logic             cmp_status,
    output logic             rise_flag,
    output logic             fall_flag,
    output logic             irq
);

    localparam int N_FLAGS = 2;

    cmpc_cfg_t         cfg_q;
    logic              cfg_chg_q;
    logic [SYNC_STAGES-1:0] sync_q;
    logic              cmp_q;
    cmpc_state_e       state_q, state_d;
    cmpc_cls_e         cur_cls, tgt_cls;
    logic              clocked, flush, shift;
    logic              cond_q, primed_q;
    logic              dec_ok, dec_val, edge_hit, edge_up;
    logic [N_FLAGS-1:0] flag_set, flag_clr, flags;

    // input synchroniser, depth chosen by parameter
    if (SYNC_STAGES == 1) begin : g_sync1
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= cmp_raw;
        end
    end else begin : g_syncn
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], cmp_raw};
        end
    end
    assign cmp_q = sync_q[SYNC_STAGES-1];

    // control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            cfg_chg_q <= 1'b0;
        end else begin
            cfg_chg_q <= cfg_we && (cfg_wdata[RESTART_W-1:0] != cfg_q[RESTART_W-1:0]);
            if (cfg_we) cfg_q <= cmpc_cfg_t'(cfg_wdata);
        end
    end

    assign clocked = !cfg_q.cont_mode || cfg_q.hold_req || sar_busy;

    always_comb begin
        if (!cfg_q.enable) tgt_cls = C_OFF;
        else if (clocked)  tgt_cls = C_CLK;
        else               tgt_cls = C_CONT;
    end

    always_comb begin
        unique case (state_q)
            S_OFF:        cur_cls = C_OFF;
            S_AZ, S_EVAL: cur_cls = C_CLK;
            S_CONT:       cur_cls = C_CONT;
        endcase
    end

    assign flush = cfg_chg_q || (tgt_cls != cur_cls);
    assign shift = (state_q == S_EVAL) && !flush;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (flush) begin
            unique case (tgt_cls)
                C_OFF:   state_d = S_OFF;
                C_CLK:   state_d = S_AZ;
                default: state_d = S_CONT;
            endcase
        end else begin
            unique case (state_q)
                S_AZ:    state_d = S_EVAL;
                S_EVAL:  state_d = S_AZ;
                S_OFF:   state_d = S_OFF;
                S_CONT:  state_d = S_CONT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_OFF;
        else        state_q <= state_d;
    end

    cmpc_window #(
        .MAJ_LEN (MAJ_LEN),
        .MAJ_THR (MAJ_THR)
    ) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .shift   (shift),
        .sample  (cmp_q),
        .filt    (cfg_q.filt),
        .dec_ok  (dec_ok),
        .dec_val (dec_val)
    );

    // conditioned result per state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_q   <= 1'b0;
            primed_q <= 1'b0;
        end else if (flush) begin
            primed_q <= 1'b0;
            if (tgt_cls == C_OFF) cond_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_OFF:  cond_q <= 1'b0;
                S_CONT: cond_q <= cmp_q;
                S_AZ:   cond_q <= cond_q;
                S_EVAL: begin
                    if (dec_ok) begin
                        cond_q   <= dec_val;
                        primed_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign edge_hit = shift && dec_ok && primed_q && (dec_val != cond_q);
    assign edge_up  = dec_val ^ cfg_q.invert;
    assign flag_set = {edge_hit && !edge_up, edge_hit && edge_up};
    assign flag_clr = {clr_we && clr_wdata[1], clr_we && clr_wdata[0]};

    cmpc_flags #(
        .N_FLAGS (N_FLAGS)
    ) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (flag_set),
        .clr_i  (flag_clr),
        .flag_o (flags)
    );

    // outputs
    assign rise_flag  = flags[0];
    assign fall_flag  = flags[1];
    assign cmp_status = cond_q;
    assign cmp_pin    = (state_q == S_OFF) ? 1'b0 : (cond_q ^ cfg_q.invert);
    assign irq        = (rise_flag && cfg_q.rise_ie) || (fall_flag && cfg_q.fall_ie);

    // R4: flags only rise after an evaluation cycle of clocked mode
    assert_rise_clk_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rise_flag) |-> $past(state_q == S_EVAL));
    assert_fall_clk_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fall_flag) |-> $past(state_q == S_EVAL));

    // R2: the result holds through an auto-zero cycle
    assert_az_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_AZ && !flush) |=> $stable(cond_q));

    // R12: disabled block keeps its result at zero
    assert_off_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_OFF && !flush) |=> (!cmp_status && !cmp_pin));

    // R10: no flag rises in the cycle right after a restart
    assert_no_flag_after_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !$rose(rise_flag) && !$rose(fall_flag));

endmodule

// File: tb/test_cmp_conditioner.sv
`timescale 1ns/1ps
module test_cmp_conditioner;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_raw = 1'b0;
    logic       sar_busy = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       clr_we = 1'b0;
    logic [1:0] clr_wdata = '0;
    logic       cmp_pin, cmp_status, rise_flag, fall_flag, irq;

    int n_cmp = 0;
    int n_bad = 0;

    localparam logic [7:0] EN   = 8'h01;
    localparam logic [7:0] CT   = 8'h02;
    localparam logic [7:0] HOLD = 8'h04;
    localparam logic [7:0] INV  = 8'h08;
    localparam logic [7:0] F2   = 8'h10;
    localparam logic [7:0] F3   = 8'h20;
    localparam logic [7:0] FMAJ = 8'h30;
    localparam logic [7:0] RIE  = 8'h40;
    localparam logic [7:0] FIE  = 8'h80;

    always #4 clk = ~clk;

    cmp_conditioner i_cmp_conditioner (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_raw    (cmp_raw),
        .sar_busy   (sar_busy),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .clr_we     (clr_we),
        .clr_wdata  (clr_wdata),
        .cmp_pin    (cmp_pin),
        .cmp_status (cmp_status),
        .rise_flag  (rise_flag),
        .fall_flag  (fall_flag),
        .irq        (irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clr_write(input logic [1:0] v);
        @(negedge clk);
        clr_we = 1'b1;
        clr_wdata = v;
        @(negedge clk);
        clr_we = 1'b0;
        clr_wdata = '0;
    endtask

    task automatic t_reset;
        chk("R1", "pin after reset", cmp_pin, 0);
        chk("R1", "status after reset", cmp_status, 0);
        chk("R1", "rise after reset", rise_flag, 0);
        chk("R1", "fall after reset", fall_flag, 0);
        chk("R1", "irq after reset", irq, 0);
    endtask

    task automatic t_basic;
        cmp_raw = 1'b0;
        cfg_write(EN);
        wait_cyc(12);
        chk("R1", "no flag at baseline", rise_flag | fall_flag, 0);
        cmp_raw = 1'b1;
        wait_cyc(8);
        chk("R1", "rise in default clocked mode", rise_flag, 1);
        chk("R1", "status follows", cmp_status, 1);
        chk("R7", "pin true polarity", cmp_pin, 1);
        chk("R1", "no fall", fall_flag, 0);
        wait_cyc(10);
        chk("R8", "rise sticky", rise_flag, 1);
        clr_write(2'b01);
        chk("R8", "rise cleared", rise_flag, 0);
        wait_cyc(10);
        chk("R8", "rise stays clear", rise_flag, 0);
        cmp_raw = 1'b0;
        wait_cyc(8);
        chk("R8", "fall set", fall_flag, 1);
        chk("R8", "rise unaffected", rise_flag, 0);
        clr_write(2'b10);
        chk("R8", "fall cleared", fall_flag, 0);
    endtask

    task automatic t_invert;
        cfg_write(EN | INV);
        wait_cyc(12);
        chk("R7", "inverted pin low input", cmp_pin, 1);
        chk("R7", "status true polarity", cmp_status, 0);
        cmp_raw = 1'b1;
        wait_cyc(8);
        chk("R7", "fall flag on pin 1->0", fall_flag, 1);
        chk("R7", "no rise flag", rise_flag, 0);
        chk("R7", "pin inverted", cmp_pin, 0);
        clr_write(2'b11);
        cmp_raw = 1'b0;
        wait_cyc(8);
        chk("R7", "rise flag on pin 0->1", rise_flag, 1);
        clr_write(2'b11);
    endtask

    task automatic t_filt(input logic [7:0] sel, input int k, input int exp, input string req);
        cfg_write(EN | sel);
        cmp_raw = 1'b0;
        wait_cyc(20);
        clr_write(2'b11);
        cmp_raw = 1'b1;
        wait_cyc(2 * k);
        cmp_raw = 1'b0;
        wait_cyc(20);
        chk(req, $sformatf("rise sel=%0h samples=%0d", sel, k), rise_flag, exp);
        chk(req, $sformatf("fall sel=%0h samples=%0d", sel, k), fall_flag, exp);
        clr_write(2'b11);
    endtask

    task automatic t_filters;
        t_filt(8'h00, 1, 1, "R5");
        t_filt(F2, 1, 0, "R5");
        t_filt(F2, 2, 1, "R5");
        t_filt(F3, 2, 0, "R5");
        t_filt(F3, 3, 1, "R5");
        t_filt(FMAJ, 2, 0, "R6");
        t_filt(FMAJ, 3, 1, "R6");
    endtask

    task automatic t_blank;
        int changes;
        logic prev;
        cfg_write(EN);
        cmp_raw = 1'b0;
        wait_cyc(14);
        changes = 0;
        prev = cmp_status;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (i > 12) begin
                if (cmp_status != prev) changes++;
            end
            prev = cmp_status;
            cmp_raw = ~cmp_raw;
            clr_we = (i == 10);
            clr_wdata = 2'b11;
        end
        clr_we = 1'b0;
        cmp_raw = 1'b0;
        chk("R2", "status changes under per-cycle toggle", changes, 0);
        chk("R2", "no flags under per-cycle toggle", rise_flag | fall_flag, 0);
        wait_cyc(10);
        clr_write(2'b11);
    endtask

    task automatic t_collide;
        int rise_hi;
        int fall_hi;
        cfg_write(EN);
        cmp_raw = 1'b0;
        wait_cyc(14);
        clr_write(2'b11);
        rise_hi = 0;
        fall_hi = 0;
        clr_we = 1'b1;
        clr_wdata = 2'b11;
        cmp_raw = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (rise_flag) rise_hi++;
        end
        cmp_raw = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (fall_flag) fall_hi++;
        end
        clr_we = 1'b0;
        clr_wdata = '0;
        chk("R9", "rise cycles seen under held clear", rise_hi, 1);
        chk("R9", "fall cycles seen under held clear", fall_hi, 1);
    endtask

    task automatic t_refill;
        cfg_write(EN);
        cmp_raw = 1'b1;
        wait_cyc(12);
        clr_write(2'b11);
        chk("R10", "status high before restart", cmp_status, 1);
        cfg_write(EN | F3);
        cmp_raw = 1'b0;
        wait_cyc(20);
        chk("R10", "baseline status", cmp_status, 0);
        chk("R10", "no fall on baseline", fall_flag, 0);
        chk("R10", "no rise on baseline", rise_flag, 0);
        cmp_raw = 1'b1;
        wait_cyc(20);
        chk("R10", "edges resume after refill", rise_flag, 1);
        clr_write(2'b11);
    endtask

    task automatic t_cont;
        cfg_write(EN | CT);
        cmp_raw = 1'b0;
        wait_cyc(6);
        clr_write(2'b11);
        cmp_raw = 1'b1;
        @(negedge clk);
        chk("R4", "status one clock after input", cmp_status, 0);
        @(negedge clk);
        chk("R4", "status two clocks after input", cmp_status, 1);
        cmp_raw = 1'b0;
        @(negedge clk);
        cmp_raw = 1'b1;
        @(negedge clk);
        chk("R4", "one-cycle pulse visible", cmp_status, 0);
        @(negedge clk);
        chk("R4", "pulse ends", cmp_status, 1);
        wait_cyc(6);
        chk("R4", "no rise in continuous", rise_flag, 0);
        chk("R4", "no fall in continuous", fall_flag, 0);
    endtask

    task automatic t_modes;
        sar_busy = 1'b1;
        wait_cyc(14);
        clr_write(2'b11);
        cmp_raw = 1'b0;
        wait_cyc(8);
        chk("R3", "sar_busy forces clocked flags", fall_flag, 1);
        sar_busy = 1'b0;
        wait_cyc(4);
        clr_write(2'b11);
        cfg_write(EN | CT | HOLD);
        wait_cyc(14);
        cmp_raw = 1'b1;
        wait_cyc(8);
        chk("R3", "hold request forces clocked flags", rise_flag, 1);
        clr_write(2'b11);
    endtask

    task automatic t_irq;
        cfg_write(EN | RIE);
        wait_cyc(14);
        clr_write(2'b11);
        cmp_raw = 1'b0;
        wait_cyc(8);
        chk("R11", "fall set", fall_flag, 1);
        chk("R11", "irq masked", irq, 0);
        cfg_write(EN | FIE);
        chk("R11", "irq on fall enable", irq, 1);
        chk("R11", "ie write keeps flag", fall_flag, 1);
        clr_write(2'b10);
        chk("R11", "irq drops on clear", irq, 0);
        cmp_raw = 1'b1;
        wait_cyc(8);
        chk("R11", "rise with rie off", irq, 0);
        cfg_write(EN | RIE | FIE);
        chk("R11", "irq on rise enable", irq, 1);
        clr_write(2'b11);
    endtask

    task automatic t_disable;
        cfg_write(INV);
        wait_cyc(4);
        chk("R12", "pin low while off", cmp_pin, 0);
        chk("R12", "status low while off", cmp_status, 0);
        cmp_raw = 1'b0;
        wait_cyc(10);
        cmp_raw = 1'b1;
        wait_cyc(10);
        chk("R12", "no flags while off", rise_flag | fall_flag, 0);
        chk("R12", "status stays low", cmp_status, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_invert();
        t_filters();
        t_blank();
        t_collide();
        t_refill();
        t_cont();
        t_modes();
        t_irq();
        t_disable();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule